// File: doc/BRIEF.md
# Cell-Storage Window Configuration Registers

This block holds the two 64-bit configuration words that place a cell-storage window in the address space and split it into equal cells. A bus master reads and writes the words by byte address; the word index is the address with its three low bits dropped. Each write only touches the fields that are meant to be writable and leaves every other bit alone. Among the bits left alone is a read-only count of the storage cells, loaded at reset from two elaboration parameters.

From the stored words the block publishes the window base, an enable bit, the window size in bytes and the cell stride in bytes. These published values are refreshed only by a write that actually changes a stored word. A new size is accepted only when it is a power of two; otherwise the old size stays. A one-cycle pulse marks every edge at which a published value changed, so that downstream address decode can capture the new window. Matching bus addresses against the window and the cells themselves belong to other blocks.

Top module: `swin_addr_map`

## Requirements
- R1: Reset is synchronous and active high. After reset, word 0 reads 0. Word 1 reads 0x0C00 (size field taken from 4096-1) ORed with the total cell count (NUM_FIFO + NUM_SEM) placed at bits 25:20. The published base is 0, enable is 0, size is 4096 and stride is 128.
- R2: `rd_data` is combinational from `acc_addr`. Index = `acc_addr >> 3`. Index 0 returns word 0, index 1 returns word 1, and every higher index returns 0.
- R3: A write to index 0 stores only bits 31:10 (base) and bit 0 (enable). All other bits of word 0 keep their old value.
- R4: A write to index 1 stores only bits 16:10 (size field) and bits 2:0 (grain). The cell count in bits 25:20 and all other bits keep their old value.
- R5: A write to an index above 1 changes no stored word and no published value. `wr_err` is high, combinationally, for as long as such a write is presented.
- R6: The published base equals word 0 bits 31:10 with ten zero bits below. The published enable equals word 0 bit 0. Both are visible from the clock edge that stores the write.
- R7: The candidate size is 1024 plus (word 1 AND 0x1FC00). It is published only if it is a power of two. Otherwise the previously published size is kept.
- R8: The published stride is 2 to the power (7 + grain) bytes, where grain is word 1 bits 2:0. This gives 128 at minimum and 16384 at maximum.
- R9: `cfg_changed` is high for exactly the one cycle after an edge at which any published value (base, enable, size or stride) changed. It is low otherwise.
- R10: A write that leaves both stored words unchanged, for example a rewrite of identical field values, changes no published value and raises no `cfg_changed` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data for `acc_addr` |
| wr_err | output | 1 | Write addressed to an unimplemented index |
| win_base | output | 32 | Published window base address |
| win_en | output | 1 | Published window enable |
| win_size | output | 18 | Published window size in bytes |
| cell_stride | output | 15 | Published cell stride in bytes |
| cfg_changed | output | 1 | One-cycle pulse on a change of published values |

## Verification
The bench builds the block with 12 FIFO cells and 9 semaphore cells. This gives a count of 21, whose field 0b010101 shows at once if a bit is lost or shifted or if the field is overwritten. An ADDR_W of 6 gives eight indices, so six of them are out of range and reachable from both reads and writes. The size field covers all 128 values, so random writes hit both accepted powers of two and rejected sizes; directed writes cover the smallest and largest size, the largest grain and identical rewrites.

// File: rtl/swin_pkg.sv
package swin_pkg;
    localparam int WORD_W     = 64;
    localparam int SIZE_W     = 18;
    localparam int STRIDE_W   = 15;
    localparam int CNT_LSB    = 20;
    localparam int CNT_W      = 6;
    localparam int RESET_SPAN = 4096;

    localparam logic [WORD_W-1:0] W0_WMASK   = 64'h0000_0000_FFFF_FC01;
    localparam logic [WORD_W-1:0] W1_WMASK   = 64'h0000_0000_0001_FC07;
    localparam logic [WORD_W-1:0] SPAN_FIELD = 64'h0000_0000_0001_FC00;

    typedef struct packed {
        logic [31:0]         base;
        logic                en;
        logic [SIZE_W-1:0]   size;
        logic [STRIDE_W-1:0] stride;
    } win_cfg_t;

    function automatic logic [SIZE_W-1:0] span_of(input logic [WORD_W-1:0] w1);
        return SIZE_W'(1024) + {1'b0, w1[16:10], 10'd0};
    endfunction

    function automatic logic is_pow2(input logic [SIZE_W-1:0] x);
        return (x != '0) && ((x & (x - SIZE_W'(1))) == '0);
    endfunction

    function automatic logic [STRIDE_W-1:0] stride_of(input logic [WORD_W-1:0] w1);
        return STRIDE_W'(1) << (int'(w1[2:0]) + 7);
    endfunction

    function automatic win_cfg_t cfg_from(input logic [WORD_W-1:0] w0,
                                          input logic [WORD_W-1:0] w1,
                                          input logic [SIZE_W-1:0] prev_size);
        win_cfg_t c;
        c.base   = {w0[31:10], 10'd0};
        c.en     = w0[0];
        c.size   = is_pow2(span_of(w1)) ? span_of(w1) : prev_size;
        c.stride = stride_of(w1);
        return c;
    endfunction
endpackage

// File: rtl/swin_regfile.sv
module swin_regfile
    import swin_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter logic [WORD_W-1:0] RST_W1 = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              wr_err,
    output logic [WORD_W-1:0] w0_q,
    output logic [WORD_W-1:0] w1_q,
    output logic [WORD_W-1:0] w0_n,
    output logic [WORD_W-1:0] w1_n,
    output logic              commit
);
    logic sel0, sel1;

    always_comb begin
        sel0   = (idx == IDX_W'(0));
        sel1   = (idx == IDX_W'(1));
        wr_err = wr_en && !sel0 && !sel1;
        w0_n   = (wr_en && sel0) ? ((wr_data & W0_WMASK) | (w0_q & ~W0_WMASK)) : w0_q;
        w1_n   = (wr_en && sel1) ? ((wr_data & W1_WMASK) | (w1_q & ~W1_WMASK)) : w1_q;
        commit = (w0_n != w0_q) || (w1_n != w1_q);
        if (sel0)      rd_data = w0_q;
        else if (sel1) rd_data = w1_q;
        else           rd_data = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w0_q <= '0;
            w1_q <= RST_W1;
        end else begin
            w0_q <= w0_n;
            w1_q <= w1_n;
        end
    end
endmodule

// File: rtl/swin_derive.sv
module swin_derive
    import swin_pkg::*;
#(
    parameter logic [WORD_W-1:0] RST_W1 = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [WORD_W-1:0] w0_n,
    input  logic [WORD_W-1:0] w1_n,
    output win_cfg_t          cfg_q,
    output logic              changed_q
);
    win_cfg_t cand;

    always_comb cand = cfg_from(w0_n, w1_n, cfg_q.size);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= cfg_from('0, RST_W1, SIZE_W'(RESET_SPAN));
            changed_q <= 1'b0;
        end else begin
            changed_q <= commit && (cand != cfg_q);
            if (commit) cfg_q <= cand;
        end
    end
endmodule

// File: rtl/swin_addr_map.sv
module swin_addr_map
    import swin_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int NUM_FIFO = 16,
    parameter int NUM_SEM  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic                wr_en,
    input  logic [63:0]         wr_data,
    output logic [63:0]         rd_data,
    output logic                wr_err,
    output logic [31:0]         win_base,
    output logic                win_en,
    output logic [17:0]         win_size,
    output logic [14:0]         cell_stride,
    output logic                cfg_changed
);
    localparam int IDX_W    = ADDR_W - 3;
    localparam int CELL_CNT = NUM_FIFO + NUM_SEM;
    localparam logic [WORD_W-1:0] RST_W1 =
        (WORD_W'(RESET_SPAN - 1) & SPAN_FIELD) | (WORD_W'(CELL_CNT) << CNT_LSB);

    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] w0_q, w1_q, w0_n, w1_n;
    logic              commit;
    win_cfg_t          cfg_q;

    assign idx = acc_addr[ADDR_W-1:3];

    swin_regfile #(.IDX_W(IDX_W), .RST_W1(RST_W1)) regs_i (
        .clk(clk), .rst(rst), .idx(idx), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .wr_err(wr_err), .w0_q(w0_q), .w1_q(w1_q),
        .w0_n(w0_n), .w1_n(w1_n), .commit(commit)
    );

    swin_derive #(.RST_W1(RST_W1)) derive_i (
        .clk(clk), .rst(rst), .commit(commit), .w0_n(w0_n), .w1_n(w1_n),
        .cfg_q(cfg_q), .changed_q(cfg_changed)
    );

    assign win_base    = cfg_q.base;
    assign win_en      = cfg_q.en;
    assign win_size    = cfg_q.size;
    assign cell_stride = cfg_q.stride;
endmodule

// File: rtl/swin_addr_map_chk.sv
module swin_addr_map_chk #(
    parameter int IDX_W    = 3,
    parameter int CELL_CNT = 0
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [IDX_W-1:0] idx,
    input logic [63:0]      w0_q,
    input logic [63:0]      w1_q,
    input logic [31:0]      win_base,
    input logic             win_en,
    input logic [17:0]      win_size,
    input logic [14:0]      cell_stride,
    input logic             cfg_changed
);
    a_r1_reset_window: assert property (@(posedge clk)
        rst |=> (win_base == 32'd0 && !win_en && win_size == 18'd4096 && cell_stride == 15'd128));

    a_r3_w0_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (w0_q[9:1] == '0) && (w0_q[63:32] == '0));

    a_r4_count_kept: assert property (@(posedge clk) disable iff (rst)
        w1_q[25:20] == 6'(CELL_CNT));

    a_r5_bad_index_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx > IDX_W'(1)) |=> ($stable(w0_q) && $stable(w1_q)));

    a_r7_size_pow2: assert property (@(posedge clk) disable iff (rst)
        $countones(win_size) == 1);

    a_r9_pulse_real: assert property (@(posedge clk) disable iff (rst)
        cfg_changed |-> (win_base != $past(win_base) || win_en != $past(win_en) ||
                         win_size != $past(win_size) || cell_stride != $past(cell_stride)));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(win_base) && $stable(win_en) && $stable(win_size) &&
                    $stable(cell_stride) && !cfg_changed));
endmodule

bind swin_addr_map swin_addr_map_chk #(.IDX_W(IDX_W), .CELL_CNT(CELL_CNT)) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .idx(idx), .w0_q(w0_q), .w1_q(w1_q),
    .win_base(win_base), .win_en(win_en), .win_size(win_size),
    .cell_stride(cell_stride), .cfg_changed(cfg_changed)
);

// File: tb/swin_addr_map_tb_top.sv
module swin_addr_map_tb_top;
    localparam int ADDR_W   = 6;
    localparam int NUM_FIFO = 12;
    localparam int NUM_SEM  = 9;
    localparam logic [63:0] RST_W1 = 64'h0000_0000_0150_0C00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        wr_err;
    logic [31:0] win_base;
    logic        win_en;
    logic [17:0] win_size;
    logic [14:0] cell_stride;
    logic        cfg_changed;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] m_w0, m_w1;
    logic [31:0] m_base;
    logic        m_en;
    logic [17:0] m_size;

    always #2.5 clk = ~clk;

    swin_addr_map #(.ADDR_W(ADDR_W), .NUM_FIFO(NUM_FIFO), .NUM_SEM(NUM_SEM)) dut_i (
        .clk(clk), .rst(rst), .acc_addr(acc_addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .wr_err(wr_err), .win_base(win_base), .win_en(win_en),
        .win_size(win_size), .cell_stride(cell_stride), .cfg_changed(cfg_changed)
    );

    function automatic logic [14:0] exp_stride(input logic [63:0] w1);
        return 15'(1) << (w1[2:0] + 3'd0 + 7);
    endfunction

    function automatic logic [17:0] exp_span(input logic [63:0] w1);
        return 18'd1024 + 18'(w1 & 64'h1FC00);
    endfunction

    function automatic bit pow2(input logic [17:0] x);
        return x != 0 && (x & (x - 1)) == 0;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_pub(input string req);
        check({req, " base"}, 64'(win_base), 64'(m_base));
        check({req, " en"}, 64'(win_en), 64'(m_en));
        check({req, " size"}, 64'(win_size), 64'(m_size));
        check("R8 stride", 64'(cell_stride), 64'(exp_stride(m_w1)));
    endtask

    task automatic do_write(input int idx, input logic [63:0] d, input string req);
        logic [63:0] n0, n1;
        logic [31:0] nb;
        logic        ne;
        logic [17:0] ns;
        bit          pulse;
        @(negedge clk);
        acc_addr = ADDR_W'((idx << 3) | ($urandom % 8));
        wr_en    = 1'b1;
        wr_data  = d;
        #1;
        check("R5 wr_err", 64'(wr_err), 64'(idx > 1));
        n0 = m_w0; n1 = m_w1;
        if (idx == 0) n0 = (d & 64'hFFFF_FC01) | (m_w0 & ~64'hFFFF_FC01);
        if (idx == 1) n1 = (d & 64'h1_FC07) | (m_w1 & ~64'h1_FC07);
        nb = m_base; ne = m_en; ns = m_size;
        if (n0 != m_w0 || n1 != m_w1) begin
            nb = {n0[31:10], 10'd0};
            ne = n0[0];
            if (pow2(exp_span(n1))) ns = exp_span(n1);
        end
        pulse = (nb != m_base) || (ne != m_en) || (ns != m_size) ||
                (exp_stride(n1) != exp_stride(m_w1));
        m_w0 = n0; m_w1 = n1; m_base = nb; m_en = ne; m_size = ns;
        @(negedge clk);
        wr_en = 1'b0;
        check_pub(req);
        check("R9 cfg_changed after write", 64'(cfg_changed), 64'(pulse));
    endtask

    task automatic do_read(input int idx);
        logic [63:0] e;
        @(negedge clk);
        acc_addr = ADDR_W'((idx << 3) | ($urandom % 8));
        #1;
        e = (idx == 0) ? m_w0 : (idx == 1) ? m_w1 : 64'd0;
        check(idx > 1 ? "R2 high index reads zero" : "R2 read word", rd_data, e);
        check("R9 no pulse when idle", 64'(cfg_changed), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_w0 = '0; m_w1 = RST_W1; m_base = '0; m_en = 1'b0; m_size = 18'd4096;
        #1;
        check("R1 reset base", 64'(win_base), 64'd0);
        check("R1 reset en", 64'(win_en), 64'd0);
        check("R1 reset size", 64'(win_size), 64'd4096);
        check("R1 reset stride", 64'(cell_stride), 64'd128);
        check("R1 reset pulse", 64'(cfg_changed), 64'd0);
        do_read(0);
        do_read(1);
        do_read(7);

        do_write(0, 64'hFFFF_FFFF_FFFF_FFFF, "R3 R6 word0 all ones");
        check("R3 readback", m_w0, 64'h0000_0000_FFFF_FC01);
        do_read(0);
        do_write(1, 64'hFFFF_FFFF_FFFF_FFFF, "R4 R7 word1 all ones");
        do_read(1);
        check("R4 count kept", m_w1, 64'h0000_0000_0151_FC07);
        check("R7 max size", 64'(win_size), 64'd131072);
        check("R8 max stride", 64'(cell_stride), 64'd16384);
        do_write(1, 64'h0000_1400, "R7 non pow2 size 6144 kept");
        check("R7 size kept", 64'(win_size), 64'd131072);
        do_write(1, 64'h0000_1C00, "R7 size 8192");
        do_write(1, 64'h0000_0000, "R7 min size 1024");
        check("R7 min size", 64'(win_size), 64'd1024);
        do_write(1, 64'h0000_0000, "R10 identical rewrite");
        check("R10 no pulse", 64'(cfg_changed), 64'd0);
        do_write(0, 64'h1234_5678, "R6 base");
        do_write(0, 64'h1234_5678, "R10 identical word0");
        do_write(5, 64'hFFFF_FFFF_FFFF_FFFF, "R5 bad index");
        do_read(0);
        do_read(1);

        for (int i = 0; i < 400; i++) begin
            int idx;
            logic [63:0] d;
            idx = int'($urandom % 8);
            d = {$urandom, $urandom};
            if (($urandom % 3) == 0) do_read(idx);
            else do_write(idx % 3 == 2 ? idx : idx % 2, d, "R6 R7 random write");
        end
        do_read(0);
        do_read(1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule